// File: doc/BRIEF.md
# Selectable Binary Field Multiplier

This block multiplies two elements of a small binary extension field. Each operand is a vector of polynomial coefficients over GF(2), and the result is their product reduced modulo an irreducible polynomial. The polynomial is fixed when the design is built. One parameter picks one of four field configurations:

- degree 6 with x^6 + x^3 + 1
- degree 7 with x^7 + x^4 + 1
- degree 7 with x^7 + x^3 + 1
- degree 8 with x^8 + x^4 + x^3 + x + 1

The two degree-7 choices give different product mappings over the same operand width.

The datapath uses only two-input AND and XOR logic, in two stages. The first stage forms a carry-less product of 2n-1 bits. The second stage folds the high terms x^n through x^(2n-2) back into the low n bits using the selected polynomial.

A second parameter adds a result register with a valid flag. With the register, a result appears one clock after it is requested. Without it, the block is purely combinational and the flag follows the request.

Top module: `gfm_mult`

## Requirements
- R1: In the degree-8 configuration (polynomial 0x11B, bit i = coefficient of x^i), c equals a times b reduced modulo x^8 + x^4 + x^3 + x + 1.
- R2: In the degree-6 configuration, c equals a times b reduced modulo x^6 + x^3 + 1 (polynomial 0x49).
- R3: In the first degree-7 configuration, c equals a times b reduced modulo x^7 + x^4 + 1 (polynomial 0x91).
- R4: In the second degree-7 configuration, c equals a times b reduced modulo x^7 + x^3 + 1 (polynomial 0x89).
- R5: If either operand is all zeros, the product is all zeros.
- R6: If one operand is the unit element (only bit 0 set), the product equals the other operand unchanged.
- R7: Bit i of a, b and c is the coefficient of x^i. Multiplying the top coefficient x^(n-1) by x (value 2) gives the low n bits of the reduction polynomial (0x1B, 0x09, 0x11, 0x09 for the four configurations).
- R8: With the result register enabled, a request with in_valid high at a clock edge gives out_valid high after that edge, with c holding that request's product. A clock edge with in_valid low gives out_valid low after it.
- R9: While rst_n is low, out_valid and c are cleared to zero at the next clock edge at the latest.
- R10: With the result register enabled, c keeps its value across clock edges at which in_valid is low, whatever a and b do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Request: capture the product of a and b |
| a | input | N | First operand, bit i = coefficient of x^i |
| b | input | N | Second operand, bit i = coefficient of x^i |
| c | output | N | Reduced product |
| out_valid | output | 1 | c holds a fresh product |

## Verification
The datapath has no memory. A wrong AND term or a wrong fold step in the reduction network shows at once on c for the affected operand pairs. An exhaustive operand sweep of the degree 6 and 7 configurations exposes such an error in the same cycle. A random sweep of the degree 8 configuration exposes it one clock later through the result register. A wrong register or flag state shows at the first edge after the request or idle cycle: a stale product, a missing or stuck out_valid, or a value that drifts while no request is made.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    typedef enum logic [1:0] {
        FLD_DEG6  = 2'd0,
        FLD_DEG7A = 2'd1,
        FLD_DEG7B = 2'd2,
        FLD_DEG8  = 2'd3
    } field_e;

    localparam int MAX_DEG = 8;

    // Field degree n for each configuration.
    function automatic int fld_deg(field_e f);
        unique case (f)
            FLD_DEG6:  return 6;
            FLD_DEG7A: return 7;
            FLD_DEG7B: return 7;
            default:   return 8;
        endcase
    endfunction

    // Reduction polynomial without its x^n term: x^n == low part (mod P).
    function automatic logic [MAX_DEG-1:0] fld_low(field_e f);
        unique case (f)
            FLD_DEG6:  return 8'h09;
            FLD_DEG7A: return 8'h11;
            FLD_DEG7B: return 8'h09;
            default:   return 8'h1B;
        endcase
    endfunction

endpackage

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
    parameter int N = 8,
    localparam int PW = 2 * N - 1
) (
    input  logic [N-1:0]  op_x,
    input  logic [N-1:0]  op_y,
    output logic [PW-1:0] prod
);

    // Carry-less partial product: each term is one AND, each column an XOR sum.
    always_comb begin
        prod = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                prod[i+j] = prod[i+j] ^ (op_x[i] & op_y[j]);
            end
        end
    end

endmodule

// File: rtl/gfm_fold.sv
module gfm_fold #(
    parameter int          N   = 8,
    parameter logic [N-1:0] LOW = '0,
    localparam int PW = 2 * N - 1
) (
    input  logic [PW-1:0] wide,
    output logic [N-1:0]  rem
);

    logic [PW-1:0] acc;

    // Fold from the top term down so that bits created by one step are folded by a later step.
    always_comb begin
        acc = wide;
        for (int k = PW - 1; k >= N; k--) begin
            acc[k-N +: N] = acc[k-N +: N] ^ ({N{acc[k]}} & LOW);
        end
        rem = acc[N-1:0];
    end

endmodule

// File: rtl/gfm_outstage.sv
module gfm_outstage #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] res_d,
    output logic [N-1:0] res_q,
    output logic         vld_q
);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) begin
                        res_q <= res_d;
                    end
                end
            end
        end else begin : g_pass
            assign res_q = res_d;
            assign vld_q = in_valid;
        end
    endgenerate

endmodule

// File: rtl/gfm_mult.sv
module gfm_mult
    import gfm_pkg::*;
#(
    parameter field_e FIELD   = FLD_DEG8,
    parameter bit     REG_OUT = 1'b1,
    localparam int    N       = fld_deg(FIELD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] c,
    output logic         out_valid
);

    localparam int             PW    = 2 * N - 1;
    localparam logic [MAX_DEG-1:0] LOW_W = fld_low(FIELD);
    localparam logic [N-1:0]   LOW   = LOW_W[N-1:0];

    logic [PW-1:0] wide;
    logic [N-1:0]  rem;

    gfm_clmul #(.N(N)) u_clmul (
        .op_x (a),
        .op_y (b),
        .prod (wide)
    );

    gfm_fold #(.N(N), .LOW(LOW)) u_fold (
        .wide (wide),
        .rem  (rem)
    );

    gfm_outstage #(.N(N), .REG_OUT(REG_OUT)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .res_d    (rem),
        .res_q    (c),
        .vld_q    (out_valid)
    );

endmodule

// File: rtl/gfm_mult_chk.sv
module gfm_mult_chk #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic [N-1:0] c,
    input logic         out_valid
);

    localparam logic [N-1:0] UNIT = N'(1);

    assert_req_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && in_valid) |=> out_valid);

    assert_idle_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && !in_valid) |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && !in_valid) |=> $stable(c));

    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && in_valid && (a == '0 || b == '0)) |=> (c == '0));

    assert_zero_comb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!REG_OUT && (a == '0 || b == '0)) |-> (c == '0));

    assert_unit_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && in_valid && a == UNIT) |=> (c == $past(b)));

    assert_unit_comb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!REG_OUT && a == UNIT) |-> (c == b));

    assert_reset_clear_R9: assert property (@(posedge clk)
        (REG_OUT && $rose(rst_n)) |-> (!out_valid && c == '0));

endmodule

bind gfm_mult gfm_mult_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .c         (c),
    .out_valid (out_valid)
);

// File: tb/sim_gfm_mult.sv
`timescale 1ns/1ps
module sim_gfm_mult;
    import gfm_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // degree-8, registered
    logic       iv8 = 1'b0;
    logic [7:0] a8 = '0, b8 = '0, c8;
    logic       ov8;
    // combinational variants
    logic [5:0] a6 = '0, b6 = '0, c6;
    logic [6:0] a7a = '0, b7a = '0, c7a, a7b = '0, b7b = '0, c7b;
    logic       ov6, ov7a, ov7b;

    gfm_mult #(.FIELD(FLD_DEG8), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(iv8), .a(a8), .b(b8), .c(c8), .out_valid(ov8));
    gfm_mult #(.FIELD(FLD_DEG6), .REG_OUT(1'b0)) u6 (
        .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .a(a6), .b(b6), .c(c6), .out_valid(ov6));
    gfm_mult #(.FIELD(FLD_DEG7A), .REG_OUT(1'b0)) u7a (
        .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .a(a7a), .b(b7a), .c(c7a), .out_valid(ov7a));
    gfm_mult #(.FIELD(FLD_DEG7B), .REG_OUT(1'b0)) u7b (
        .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .a(a7b), .b(b7b), .c(c7b), .out_valid(ov7b));

    // Shift-and-reduce reference; poly includes the x^n term.
    function automatic int ref_mul(int x, int y, int n, int poly);
        int r = 0;
        int s = x;
        for (int i = 0; i < n; i++) begin
            if (((y >> i) & 1) != 0) r = r ^ s;
            s = s << 1;
            if (((s >> n) & 1) != 0) s = s ^ poly;
        end
        return r;
    endfunction

    task automatic chk(string req, int got, int exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic string tag(int x, int y, string base);
        if (x == 0 || y == 0) return "R5";
        if (x == 1 || y == 1) return "R6";
        return base;
    endfunction

    initial begin
        int prev;
        // reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 out_valid", int'(ov8), 0);
        chk("R9 c", int'(c8), 0);
        rst_n = 1'b1;

        // bit ordering: top coefficient times x
        a6 = 6'h20; b6 = 6'h02; a7a = 7'h40; b7a = 7'h02; a7b = 7'h40; b7b = 7'h02;
        #1;
        chk("R7 deg6", int'(c6), 'h09);
        chk("R7 deg7a", int'(c7a), 'h11);
        chk("R7 deg7b", int'(c7b), 'h09);

        // exhaustive combinational sweeps
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                a6 = 6'(x); b6 = 6'(y); #1;
                chk(tag(x, y, "R2"), int'(c6), ref_mul(x, y, 6, 'h49));
            end
        end
        for (int x = 0; x < 128; x++) begin
            for (int y = 0; y < 128; y++) begin
                a7a = 7'(x); b7a = 7'(y); a7b = 7'(x); b7b = 7'(y); #1;
                chk(tag(x, y, "R3"), int'(c7a), ref_mul(x, y, 7, 'h91));
                chk(tag(x, y, "R4"), int'(c7b), ref_mul(x, y, 7, 'h89));
            end
        end

        // registered degree 8: bit ordering case
        @(negedge clk);
        a8 = 8'h80; b8 = 8'h02; iv8 = 1'b1;
        @(negedge clk);
        chk("R7 deg8", int'(c8), 'h1B);
        chk("R8 valid", int'(ov8), 1);

        // corner operands then random pairs
        for (int k = 0; k < 3000; k++) begin
            int x, y;
            if (k < 4) begin
                x = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 'hFF : 'h53;
                y = (k == 0) ? 'hA5 : (k == 1) ? 'h3C : (k == 2) ? 1 : 0;
            end else begin
                x = int'($urandom_range(255, 0));
                y = int'($urandom_range(255, 0));
            end
            a8 = 8'(x); b8 = 8'(y); iv8 = 1'b1;
            @(negedge clk);
            chk(tag(x, y, "R1"), int'(c8), ref_mul(x, y, 8, 'h11B));
            chk("R8 valid", int'(ov8), 1);
        end

        // idle: operands change, result must hold
        prev = int'(c8);
        iv8 = 1'b0;
        for (int k = 0; k < 5; k++) begin
            a8 = 8'(k * 37 + 5); b8 = 8'(k * 11 + 3);
            @(negedge clk);
            chk("R8 idle valid", int'(ov8), 0);
            chk("R10 hold", int'(c8), prev);
        end

        // request after idle, then reset mid-run
        a8 = 8'h57; b8 = 8'h83; iv8 = 1'b1;
        @(negedge clk);
        chk("R1 fixed", int'(c8), 'hC1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 out_valid", int'(ov8), 0);
        chk("R9 c", int'(c8), 0);
        iv8 = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule